// File: doc/BRIEF.md
# Mixed-Radix Carry-Save Residual Register

This block holds the partial remainder of a radix-4 digit-recurrence divider in redundant form and advances it by one iteration per step. Each step computes the next residual as four times the current residual minus the product of a signed quotient digit (−2..+2) and the divisor. The sum and carry vectors stay separate, so no carry ever travels the full width of the word.

The 56-bit word has two regions. The upper 8 positions use ordinary carry-save form, with one sum bit and one carry bit per position. The lower 48 positions are grouped into 24 bit pairs. Each pair stores two sum bits but only one carry bit: the carry of the pair's even slice passes directly into its odd slice during the same cycle. This saves 24 carry flip-flops. It adds one full-adder delay only in the low region, which is not the timing-critical part of the recurrence. A positive digit is subtracted by adding the inverted multiple and placing a 1 in the carry input of bit 0. That input is always free, because the shifted residual never has a carry there.

Control uses a two-state machine. `ST_IDLE` is entered at reset and means no residual has been loaded. A load moves the block to `ST_RUN` (the IDLE→RUN transition). In `ST_RUN` the block stays in `ST_RUN` on every cycle (the RUN→RUN transition), whether it loads, steps or holds. In `ST_IDLE` with no load, the block stays in `ST_IDLE` (the IDLE→IDLE transition), and step requests are ignored.

Top module: `mrcs_residual`

## Requirements
- R1: After reset the sum register and both carry registers read zero, and the machine is in `ST_IDLE`.
- R2: When `load_i` is high at a rising edge, `sum_o` takes `init_i` and `cy_lo_o` and `cy_hi_o` become zero one cycle later. The machine then enters `ST_RUN`.
- R3: When `load_i` and `step_i` are both high, the load wins and no iteration is performed.
- R4: In `ST_IDLE`, `step_i` has no effect: all registers keep their reset value of zero.
- R5: In `ST_RUN`, a cycle with `step_i` high and `load_i` low makes the residual value V' = 4·V − q·D (mod 2^56) one cycle later. The residual value V is `sum_o` plus the stored carries at these weights: `cy_lo_o[k]` has weight 2^(2k+2), and `cy_hi_o[j]` has weight 2^(49+j). D is `div_i`.
- R6: `digit_i` is a 3-bit two's-complement digit. The codes 000, 001, 010, 111 and 110 mean 0, +1, +2, −1 and −2. The codes 011, 100 and 101 act as digit 0, so a step with one of them gives V' = 4·V.
- R7: A cycle with neither `load_i` nor `step_i` high leaves all three registers unchanged, whatever `digit_i` and `div_i` carry.
- R8: A digit-0 step taken directly after a load gives `sum_o` = `init_i` shifted left by two (mod 2^56), with all stored carries zero.
- R9: Only one carry bit is stored per bit pair in the low 48 positions: `cy_lo_o` is 24 bits wide. The top carry of the high region is discarded, so `cy_hi_o` holds 7 bits. All arithmetic wraps modulo 2^56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load `init_i` as the new residual |
| init_i | input | 56 | Initial residual (dividend) |
| step_i | input | 1 | Perform one recurrence iteration |
| digit_i | input | 3 | Signed quotient digit, two's complement |
| div_i | input | 56 | Divisor |
| sum_o | output | 56 | Stored sum vector |
| cy_lo_o | output | 24 | Stored carry of each low-region bit pair |
| cy_hi_o | output | 7 | Stored carries of the high region |

## Verification
Every result is produced by one register stage. Loads, steps and holds are therefore visible exactly one rising edge after the cycle in which they are presented. The bench drives each stimulus on a falling edge and samples the outputs on the next falling edge, half a period after the capturing edge. It never looks later than that, so one step cannot hide behind the next. The bench checks chained steps against its own running model of 4·V − q·D. This makes the stored pair carries from one step feed the next, and the sampling point stays fixed at one cycle per step.

// File: rtl/mrcs_pkg.sv
package mrcs_pkg;

    localparam int DIGIT_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mrcs_state_e;

    // Decoded quotient digit: sub means the multiple is subtracted
    typedef struct packed {
        logic sub;
        logic use1;
        logic use2;
    } digit_sel_t;

    function automatic digit_sel_t decode_digit(input logic [DIGIT_W-1:0] code);
        digit_sel_t r;
        r = '0;
        case (code)
            3'b001:  begin r.sub = 1'b1; r.use1 = 1'b1; end
            3'b010:  begin r.sub = 1'b1; r.use2 = 1'b1; end
            3'b111:  r.use1 = 1'b1;
            3'b110:  r.use2 = 1'b1;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic digit_legal(input logic [DIGIT_W-1:0] code);
        return (code == 3'b000) || (code == 3'b001) || (code == 3'b010) ||
               (code == 3'b111) || (code == 3'b110);
    endfunction

endpackage

// File: rtl/mrcs_multiple_gen.sv
module mrcs_multiple_gen
    import mrcs_pkg::*;
#(
    parameter int W = 56
) (
    input  logic [W-1:0]       div_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [W-1:0]       mult_o,
    output logic               inj_o
);

    digit_sel_t   sel;
    logic [W-1:0] mag;

    always_comb begin
        sel = decode_digit(digit_i);
        mag = '0;
        if (sel.use1) begin
            mag = div_i;
        end else if (sel.use2) begin
            mag = {div_i[W-2:0], 1'b0};
        end
        // subtract = add inverted multiple plus one at bit 0
        mult_o = sel.sub ? ~mag : mag;
        inj_o  = sel.sub;
    end

endmodule

// File: rtl/mrcs_full_add.sv
module mrcs_full_add (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic co_o
);

    logic p;

    always_comb begin
        p    = a_i ^ b_i;
        s_o  = p ^ c_i;
        co_o = (a_i & b_i) | (c_i & p);
    end

endmodule

// File: rtl/mrcs_pair_cell.sv
module mrcs_pair_cell (
    input  logic a_e_i,
    input  logic a_o_i,
    input  logic b_e_i,
    input  logic m_e_i,
    input  logic m_o_i,
    output logic s_e_o,
    output logic s_o_o,
    output logic c_o_o
);

    logic c_mid;

    // even slice: shifted sum, stored carry of lower pair, multiple
    mrcs_full_add u_even (
        .a_i  (a_e_i),
        .b_i  (b_e_i),
        .c_i  (m_e_i),
        .s_o  (s_e_o),
        .co_o (c_mid)
    );

    // odd slice: even carry ripples in instead of being stored
    mrcs_full_add u_odd (
        .a_i  (a_o_i),
        .b_i  (m_o_i),
        .c_i  (c_mid),
        .s_o  (s_o_o),
        .co_o (c_o_o)
    );

    // R5: pair output weight equals input weight
    always_comb begin
        if (!$isunknown({a_e_i, a_o_i, b_e_i, m_e_i, m_o_i})) begin
            pair_sum_chk: assert ((4 * int'(c_o_o) + 2 * int'(s_o_o) + int'(s_e_o)) ==
                                  (int'(a_e_i) + int'(b_e_i) + int'(m_e_i) +
                                   2 * (int'(a_o_i) + int'(m_o_i))));
        end
    end

endmodule

// File: rtl/mrcs_csa_array.sv
module mrcs_csa_array #(
    parameter int W    = 56,
    parameter int LO_W = 48,
    localparam int PAIRS = LO_W / 2,
    localparam int HI_W  = W - LO_W
) (
    input  logic [W-1:0]      sh_sum_i,
    input  logic [W-1:0]      sh_cy_i,
    input  logic [W-1:0]      mult_i,
    input  logic              inj_i,
    output logic [W-1:0]      nx_sum_o,
    output logic [PAIRS-1:0]  nx_cy_lo_o,
    output logic [HI_W-2:0]   nx_cy_hi_o
);

    logic [W-1:0]     cin;
    logic [HI_W-1:0]  hi_co;
    logic [PAIRS-1:0] odd_cy;
    logic             unused_ok;

    // bit 0 never carries a shifted carry: it takes the +1 of a subtraction
    assign cin = {sh_cy_i[W-1:1], sh_cy_i[0] | inj_i};

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign odd_cy[k] = sh_cy_i[2*k+1];
        mrcs_pair_cell u_cell (
            .a_e_i (sh_sum_i[2*k]),
            .a_o_i (sh_sum_i[2*k+1]),
            .b_e_i (cin[2*k]),
            .m_e_i (mult_i[2*k]),
            .m_o_i (mult_i[2*k+1]),
            .s_e_o (nx_sum_o[2*k]),
            .s_o_o (nx_sum_o[2*k+1]),
            .c_o_o (nx_cy_lo_o[k])
        );
    end

    for (genvar j = 0; j < HI_W; j++) begin : g_hi
        mrcs_full_add u_fa (
            .a_i  (sh_sum_i[LO_W+j]),
            .b_i  (cin[LO_W+j]),
            .c_i  (mult_i[LO_W+j]),
            .s_o  (nx_sum_o[LO_W+j]),
            .co_o (hi_co[j])
        );
    end

    // carry out of the top position falls outside the modulus
    assign nx_cy_hi_o = hi_co[HI_W-2:0];
    assign unused_ok  = hi_co[HI_W-1] ^ (^odd_cy);

    // R9: odd low positions and bit 0 never receive a stored carry
    always_comb begin
        if (!$isunknown({odd_cy, sh_cy_i[0]})) begin
            odd_cy_zero_chk: assert (odd_cy == '0 && sh_cy_i[0] == 1'b0);
        end
    end

endmodule

// File: rtl/mrcs_residual.sv
module mrcs_residual
    import mrcs_pkg::*;
#(
    parameter int W    = 56,
    parameter int LO_W = 48,
    localparam int PAIRS = LO_W / 2,
    localparam int HI_W  = W - LO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [W-1:0]       init_i,
    input  logic               step_i,
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic [W-1:0]       div_i,
    output logic [W-1:0]       sum_o,
    output logic [PAIRS-1:0]   cy_lo_o,
    output logic [HI_W-2:0]    cy_hi_o
);

    mrcs_state_e state_q, state_d;
    logic        load_en, step_en;

    logic [W-1:0]     sum_q;
    logic [PAIRS-1:0] cy_lo_q;
    logic [HI_W-2:0]  cy_hi_q;

    logic [W-1:0]     cy_vec, sh_sum, sh_cy, mult;
    logic             inj;
    logic [W-1:0]     nx_sum;
    logic [PAIRS-1:0] nx_cy_lo;
    logic [HI_W-2:0]  nx_cy_hi;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // ---------------- output / enable decode ----------------
    always_comb begin
        load_en = load_i;
        step_en = 1'b0;
        unique case (state_q)
            ST_IDLE: step_en = 1'b0;
            ST_RUN:  step_en = step_i & ~load_i;
        endcase
    end

    // ---------------- carry placement and shift ----------------
    always_comb begin
        cy_vec = '0;
        for (int k = 0; k < PAIRS; k++) begin
            cy_vec[2*k+2] = cy_lo_q[k];
        end
        for (int j = 0; j < HI_W - 1; j++) begin
            cy_vec[LO_W+1+j] = cy_hi_q[j];
        end
    end

    assign sh_sum = {sum_q[W-3:0], 2'b00};
    assign sh_cy  = {cy_vec[W-3:0], 2'b00};

    mrcs_multiple_gen #(.W(W)) u_mgen (
        .div_i   (div_i),
        .digit_i (digit_i),
        .mult_o  (mult),
        .inj_o   (inj)
    );

    mrcs_csa_array #(.W(W), .LO_W(LO_W)) u_csa (
        .sh_sum_i   (sh_sum),
        .sh_cy_i    (sh_cy),
        .mult_i     (mult),
        .inj_i      (inj),
        .nx_sum_o   (nx_sum),
        .nx_cy_lo_o (nx_cy_lo),
        .nx_cy_hi_o (nx_cy_hi)
    );

    // ---------------- residual registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q   <= '0;
            cy_lo_q <= '0;
            cy_hi_q <= '0;
        end else if (load_en) begin
            sum_q   <= init_i;
            cy_lo_q <= '0;
            cy_hi_q <= '0;
        end else if (step_en) begin
            sum_q   <= nx_sum;
            cy_lo_q <= nx_cy_lo;
            cy_hi_q <= nx_cy_hi;
        end
    end

    assign sum_o   = sum_q;
    assign cy_lo_o = cy_lo_q;
    assign cy_hi_o = cy_hi_q;

    // ---------------- checks ----------------
    logic [W-1:0]               res_val, exp_next, exp_shift;
    logic signed [DIGIT_W-1:0]  q_eff;
    logic signed [W+DIGIT_W:0]  qd_prod;

    always_comb begin
        res_val   = sum_q + cy_vec;
        q_eff     = digit_legal(digit_i) ? $signed(digit_i) : '0;
        qd_prod   = q_eff * $signed({1'b0, div_i});
        exp_shift = {res_val[W-3:0], 2'b00};
        exp_next  = exp_shift - qd_prod[W-1:0];
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sum_q == $past(init_i)) && (cy_lo_q == '0) && (cy_hi_q == '0) &&
                   (state_q == ST_RUN));

    // R4
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load_i) |=> (sum_q == '0) && (cy_lo_q == '0) && (cy_hi_q == '0));

    // R5
    recur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && step_i && !load_i) |=> (res_val == $past(exp_next)));

    // R6
    bad_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && step_i && !load_i && !digit_legal(digit_i))
            |=> (res_val == $past(exp_shift)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(sum_q) && $stable(cy_lo_q) && $stable(cy_hi_q));

endmodule

// File: tb/mrcs_residual_bench.sv
`timescale 1ns/1ps
module mrcs_residual_bench;

    localparam int W     = 56;
    localparam int LO_W  = 48;
    localparam int PAIRS = LO_W / 2;
    localparam int HI_W  = W - LO_W;
    localparam int NTAB  = 8;

    localparam logic [W-1:0] X_TAB [NTAB] = '{
        56'h12_3456_789A_BCDE, 56'hFF_FFFF_FFFF_FFFF, 56'h00_0000_0000_0000,
        56'h80_0000_0000_0000, 56'h3F_FFFF_FFFF_FFFF, 56'hAA_AAAA_AAAA_AAAA,
        56'h55_5555_5555_5555, 56'h00_0000_0000_0003 };
    localparam logic [W-1:0] D_TAB [NTAB] = '{
        56'h80_0000_0000_0000, 56'hC0_0000_0000_0001, 56'hFF_FFFF_FFFF_FFFF,
        56'h9A_BCDE_F012_3457, 56'h80_0000_0000_0000, 56'hE5_5555_5555_5555,
        56'hFF_FFFF_FFFF_FFFF, 56'h80_0000_0000_0001 };
    localparam logic [2:0] Q_TAB [NTAB] = '{
        3'b001, 3'b010, 3'b111, 3'b110, 3'b000, 3'b001, 3'b110, 3'b010 };
    localparam logic [2:0] LEGAL [5] = '{3'b000, 3'b001, 3'b010, 3'b111, 3'b110};

    logic               clk = 1'b0;
    logic               rst_n;
    logic               load_i, step_i;
    logic [W-1:0]       init_i, div_i;
    logic [2:0]         digit_i;
    logic [W-1:0]       sum_o;
    logic [PAIRS-1:0]   cy_lo_o;
    logic [HI_W-2:0]    cy_hi_o;

    int           n_chk  = 0;
    int           n_fail = 0;
    logic [W-1:0] model;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    mrcs_residual u_mrcs_residual (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .init_i  (init_i),
        .step_i  (step_i),
        .digit_i (digit_i),
        .div_i   (div_i),
        .sum_o   (sum_o),
        .cy_lo_o (cy_lo_o),
        .cy_hi_o (cy_hi_o)
    );

    function automatic logic [W-1:0] assemble(input logic [W-1:0] s,
                                              input logic [PAIRS-1:0] lo,
                                              input logic [HI_W-2:0] hi);
        logic [W-1:0] v;
        v = s;
        for (int k = 0; k < PAIRS; k++) if (lo[k]) v = v + (W'(1) << (2*k+2));
        for (int j = 0; j < HI_W - 1; j++) if (hi[j]) v = v + (W'(1) << (LO_W+1+j));
        return v;
    endfunction

    function automatic logic [W-1:0] qmul(input logic [2:0] q, input logic [W-1:0] d);
        case (q)
            3'b001:  return d;
            3'b010:  return d << 1;
            3'b111:  return -d;
            3'b110:  return -(d << 1);
            default: return '0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] cur_val();
        return assemble(sum_o, cy_lo_o, cy_hi_o);
    endfunction

    task automatic do_load(input logic [W-1:0] x);
        load_i = 1'b1; init_i = x;
        @(negedge clk);
        load_i = 1'b0;
        model = x;
        check(sum_o == x, "R2 load sum", sum_o, x);
        check(cy_lo_o == '0 && cy_hi_o == '0, "R2 load carries",
              W'({cy_hi_o, cy_lo_o}), '0);
    endtask

    task automatic do_step(input logic [2:0] q, input logic [W-1:0] d, input string tag);
        step_i = 1'b1; digit_i = q; div_i = d;
        @(negedge clk);
        step_i = 1'b0;
        model = (model << 2) - qmul(q, d);
        check(cur_val() == model, tag, cur_val(), model);
    endtask

    initial begin
        rst_n = 1'b0; load_i = 1'b0; step_i = 1'b0;
        init_i = '0; div_i = '0; digit_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(sum_o == '0 && cy_lo_o == '0 && cy_hi_o == '0, "R1 reset",
              cur_val(), '0);

        // R4: step before any load is ignored
        step_i = 1'b1; digit_i = 3'b001; div_i = 56'h80_0000_0000_0001;
        @(negedge clk);
        step_i = 1'b0;
        check(sum_o == '0 && cy_lo_o == '0 && cy_hi_o == '0, "R4 idle step",
              cur_val(), '0);

        // R2/R5 table walk: load, then two chained steps per entry
        for (int i = 0; i < NTAB; i++) begin
            do_load(X_TAB[i]);
            do_step(Q_TAB[i], D_TAB[i], "R5 table step1");
            do_step(Q_TAB[i], D_TAB[i], "R5 table step2");
        end

        // R8: digit zero right after load
        do_load(56'hC3_1234_5678_9ABC);
        step_i = 1'b1; digit_i = 3'b000; div_i = 56'hFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        step_i = 1'b0;
        check(sum_o == 56'h0C_48D1_59E2_6AF0, "R8 zero digit sum", sum_o,
              56'h0C_48D1_59E2_6AF0);
        check(cy_lo_o == '0 && cy_hi_o == '0, "R8 zero digit carries",
              W'({cy_hi_o, cy_lo_o}), '0);
        model = 56'h0C_48D1_59E2_6AF0;

        // R7: hold with changing digit and divisor
        do_step(3'b110, 56'h9F_0F0F_0F0F_0F0F, "R5 pre-hold");
        begin
            logic [W-1:0]     s0;
            logic [PAIRS-1:0] l0;
            logic [HI_W-2:0]  h0;
            s0 = sum_o; l0 = cy_lo_o; h0 = cy_hi_o;
            digit_i = 3'b010; div_i = 56'h12_3412_3412_3412;
            repeat (3) @(negedge clk);
            check(sum_o == s0 && cy_lo_o == l0 && cy_hi_o == h0, "R7 hold",
                  cur_val(), assemble(s0, l0, h0));
        end

        // R6: illegal codes act as digit zero
        do_step(3'b011, 56'hFF_0000_FFFF_0000, "R6 code 011");
        do_step(3'b100, 56'hFF_0000_FFFF_0000, "R6 code 100");
        do_step(3'b101, 56'hFF_0000_FFFF_0000, "R6 code 101");

        // R3: load beats step
        load_i = 1'b1; step_i = 1'b1; init_i = 56'h01_0203_0405_0607;
        digit_i = 3'b001; div_i = 56'h80_0000_0000_0000;
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0;
        model = 56'h01_0203_0405_0607;
        check(cur_val() == model && cy_lo_o == '0 && cy_hi_o == '0, "R3 load priority",
              cur_val(), model);

        // R5/R9: random chained steps, all five digits, periodic reload
        for (int n = 0; n < 400; n++) begin
            if (n % 32 == 0) begin
                do_load(W'({$urandom, $urandom}));
            end
            do_step(LEGAL[$urandom_range(4, 0)], W'({$urandom, $urandom}),
                    "R5 R9 random chain");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule